// File: doc/BRIEF.md
# Command Handshake Controller

This block holds the four control words of a buffer-based command interface and the state machine behind them. Software moves the device through four states: idle, ready, executing and completed. It does this by writing a request word, a start word and a cancel word, and it reads a status word back. An execution engine outside the block receives a one-cycle start strobe when a command is launched and a one-cycle cancel strobe when an abort is asked for. The engine answers with a one-cycle done pulse when execution ends.

Request bits follow a set-by-software, clear-by-hardware rule. Software sets a bit, and hardware clears it at the clock edge where the state change it asked for takes place. Each request bit has its own cycle counter. If a bit stays set for `TIMEOUT_CYC` consecutive cycles without being served, a fatal-error flag is raised. That flag can only be cleared by reset. The start and cancel words act on the full 32-bit value written, not on a single bit.

Register access uses a plain single-cycle write port and a combinational read port. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. The write index selects one word: 0 is request, 1 is status, 2 is cancel, 3 is start.

Top module: `cmdif_ctrl`

## Requirements
- R1: After reset the device is idle. Word 1 (status) reads 0x00000002, and words 0, 2 and 3 read zero. `eng_start` and `eng_cancel` are low.
- R2: A write to word 0 ORs its bits 1:0 into the request bits (bit 1 go-idle, bit 0 command-ready). Writing zeros never clears a pending bit.
- R3: While not executing, a pending command-ready bit with no go-idle pending moves the device to ready and clears the bit one edge after the bit appears. Status bit 1 (idle) then reads 0. While executing, the bit stays pending.
- R4: While not executing, a pending go-idle bit moves the device to idle, clears the bit and sets status bit 1. When both bits are pending, go-idle is served first and command-ready on the following edge.
- R5: Writing exactly 0x00000001 to word 3 while ready starts execution. Word 3 then reads 1, and `eng_start` is high for exactly the next cycle. In any other state, and for any other value, the write has no effect.
- R6: A `eng_done` pulse while executing returns word 3 to 0 and enters the completed state, from which command-ready leads to ready and go-idle leads to idle. Outside execution, `eng_done` has no effect.
- R7: Writing 0x00000001 to word 2 makes it read 1, and writing 0x00000000 makes it read 0. Other values are ignored. A write of 0x00000001 while executing also raises `eng_cancel` for one cycle.
- R8: A request bit that stays set for `TIMEOUT_CYC` consecutive clock edges sets status bit 0 (fatal) on the last of those edges.
- R9: Once set, the fatal bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_waddr | input | 2 | Word index of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Word index of the read |
| reg_rdata | output | 32 | Combinational read data |
| eng_done | input | 1 | Engine finished the current command |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_cancel | output | 1 | One-cycle abort strobe to the engine |

## Verification
The assertions assume that `eng_done` is a single-cycle pulse and that the engine raises it only after it has seen `eng_start`. Without that, the completion checks would have nothing to relate to. They also assume writes arrive one word per cycle on a stable index. The stimulus drives every input at the falling edge and holds it for one full cycle. It pulses `eng_done` only once execution has begun, except in the deliberate done-while-idle and done-while-completed cases, where the block must ignore the pulse.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } cmd_state_e;

  localparam int unsigned IDX_W    = 2;
  localparam int unsigned REQ_BITS = 2;
  localparam int unsigned BIT_RDY  = 0;
  localparam int unsigned BIT_IDLE = 1;

  localparam logic [IDX_W-1:0] IDX_REQ = 2'd0;
  localparam logic [IDX_W-1:0] IDX_STS = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CAN = 2'd2;
  localparam logic [IDX_W-1:0] IDX_GO  = 2'd3;

endpackage

// File: rtl/cmdif_req_timer.sv
module cmdif_req_timer
  import cmdif_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REQ_BITS-1:0] req_i,
  output logic [REQ_BITS-1:0] expired_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  // one independent age counter per request bit
  for (genvar b = 0; b < REQ_BITS; b++) begin : g_bit
    logic [CNT_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q <= '0;
      end else if (!req_i[b]) begin
        age_q <= '0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end

    // the edge that sees the bit set for the TIMEOUT_CYC-th time
    assign expired_o[b] = req_i[b] && (age_q == LAST);
  end

endmodule

// File: rtl/cmdif_fsm.sv
module cmdif_fsm
  import cmdif_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_wr_i,
  input  logic                done_i,
  input  logic [REQ_BITS-1:0] req_i,
  output cmd_state_e          state_o,
  output logic [REQ_BITS-1:0] ack_o,
  output logic                start_bit_o,
  output logic                eng_start_o
);

  cmd_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       launch;
  logic       finish;

  assign launch = start_wr_i && (state_q == ST_READY);
  assign finish = done_i && (state_q == ST_EXEC);

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    ack_o   = '0;
    if (launch) begin
      state_d = ST_EXEC;
      start_d = 1'b1;
    end else if (state_q == ST_EXEC) begin
      if (finish) begin
        state_d = ST_DONE;
        start_d = 1'b0;
      end
    end else if (req_i[BIT_IDLE]) begin
      // response consumed: go-idle served before command-ready
      state_d          = ST_IDLE;
      ack_o[BIT_IDLE]  = 1'b1;
    end else if (req_i[BIT_RDY]) begin
      state_d          = ST_READY;
      ack_o[BIT_RDY]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      start_q     <= 1'b0;
      eng_start_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_q     <= start_d;
      eng_start_o <= launch;
    end
  end

  assign state_o     = state_q;
  assign start_bit_o = start_q;

endmodule

// File: rtl/cmdif_regs.sv
module cmdif_regs
  import cmdif_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    waddr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0]    raddr_i,
  input  logic [REQ_BITS-1:0] ack_i,
  input  logic [REQ_BITS-1:0] expired_i,
  input  cmd_state_e          state_i,
  input  logic                start_bit_i,
  output logic [REQ_BITS-1:0] req_o,
  output logic                fatal_o,
  output logic                cancel_o,
  output logic                eng_cancel_o,
  output logic [DATA_W-1:0]   rdata_o
);

  localparam logic [DATA_W-1:0] WORD_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] WORD_ZERO = '0;

  logic [REQ_BITS-1:0] req_q;
  logic [REQ_BITS-1:0] req_set;
  logic                fatal_q;
  logic                cancel_q;
  logic                wr_req, wr_can;
  logic                can_one, can_zero;

  assign wr_req   = wr_i && (waddr_i == IDX_REQ);
  assign wr_can   = wr_i && (waddr_i == IDX_CAN);
  assign can_one  = wr_can && (wdata_i == WORD_ONE);
  assign can_zero = wr_can && (wdata_i == WORD_ZERO);
  assign req_set  = wr_req ? wdata_i[REQ_BITS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q        <= '0;
      fatal_q      <= 1'b0;
      cancel_q     <= 1'b0;
      eng_cancel_o <= 1'b0;
    end else begin
      req_q        <= (req_q & ~ack_i) | req_set;
      fatal_q      <= fatal_q | (|expired_i);
      eng_cancel_o <= can_one && (state_i == ST_EXEC);
      if (can_one) begin
        cancel_q <= 1'b1;
      end else if (can_zero) begin
        cancel_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      IDX_REQ: rdata_o[REQ_BITS-1:0] = req_q;
      IDX_STS: begin
        rdata_o[1] = (state_i == ST_IDLE);
        rdata_o[0] = fatal_q;
      end
      IDX_CAN: rdata_o[0] = cancel_q;
      IDX_GO:  rdata_o[0] = start_bit_i;
      default: rdata_o = '0;
    endcase
  end

  assign req_o    = req_q;
  assign fatal_o  = fatal_q;
  assign cancel_o = cancel_q;

endmodule

// File: rtl/cmdif_ctrl.sv
module cmdif_ctrl
  import cmdif_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              eng_cancel
);

  localparam logic [DATA_W-1:0] GO_WORD = DATA_W'(1);

  cmd_state_e          state_q;
  logic [REQ_BITS-1:0] req_q;
  logic [REQ_BITS-1:0] ack;
  logic [REQ_BITS-1:0] expired;
  logic                start_bit;
  logic                fatal_q;
  logic                cancel_q;
  logic                start_wr;

  assign start_wr = reg_wr && (reg_waddr == IDX_GO) && (reg_wdata == GO_WORD);

  cmdif_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_wr_i  (start_wr),
    .done_i      (eng_done),
    .req_i       (req_q),
    .state_o     (state_q),
    .ack_o       (ack),
    .start_bit_o (start_bit),
    .eng_start_o (eng_start)
  );

  cmdif_req_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_q),
    .expired_o (expired)
  );

  cmdif_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (reg_wr),
    .waddr_i      (reg_waddr),
    .wdata_i      (reg_wdata),
    .raddr_i      (reg_raddr),
    .ack_i        (ack),
    .expired_i    (expired),
    .state_i      (state_q),
    .start_bit_i  (start_bit),
    .req_o        (req_q),
    .fatal_o      (fatal_q),
    .cancel_o     (cancel_q),
    .eng_cancel_o (eng_cancel),
    .rdata_o      (reg_rdata)
  );

endmodule

// File: rtl/cmdif_ctrl_chk.sv
module cmdif_ctrl_chk
  import cmdif_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input cmd_state_e          state_q,
  input logic [REQ_BITS-1:0] req_q,
  input logic                start_bit,
  input logic                fatal_q,
  input logic                eng_start,
  input logic                eng_cancel
);

  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_q |=> fatal_q);

  p_fatal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_q) |-> $past(|req_q));

  p_ready_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q[BIT_RDY]) |-> (state_q == ST_READY));

  p_idle_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q[BIT_IDLE]) |-> (state_q == ST_IDLE));

  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (state_q == ST_EXEC) && start_bit && ($past(state_q) == ST_READY));

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_bit) |-> (state_q == ST_DONE));

  p_exec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> start_bit);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cancel |-> ($past(state_q) == ST_EXEC));

endmodule

bind cmdif_ctrl cmdif_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_q    (state_q),
  .req_q      (req_q),
  .start_bit  (start_bit),
  .fatal_q    (fatal_q),
  .eng_start  (eng_start),
  .eng_cancel (eng_cancel)
);

// File: tb/cmdif_ctrl_tb.sv
module cmdif_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        eng_done = 1'b0;
  logic        eng_start;
  logic        eng_cancel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model: 0 idle, 1 ready, 2 exec, 3 completed
  int       m_st;
  bit [1:0] m_req;
  bit       m_start, m_cancel, m_fatal, m_es, m_ec;
  int       m_age [2];

  cmdif_ctrl #(.DATA_W(32), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .eng_done(eng_done), .eng_start(eng_start), .eng_cancel(eng_cancel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic model_reset();
    m_st = 0; m_req = 0; m_start = 0; m_cancel = 0; m_fatal = 0;
    m_es = 0; m_ec = 0; m_age[0] = 0; m_age[1] = 0;
  endtask

  task automatic model_edge(bit w, bit [1:0] a, logic [31:0] d, bit dn);
    bit       acc;
    bit [1:0] served;
    acc = w && a == 3 && d == 32'h1 && m_st == 1;
    m_ec = w && a == 2 && d == 32'h1 && m_st == 2;
    m_es = acc;
    if (w && a == 2 && d == 32'h1) m_cancel = 1;
    else if (w && a == 2 && d == 32'h0) m_cancel = 0;
    for (int b = 0; b < 2; b++) begin
      if (m_req[b]) begin
        if (m_age[b] == TMO - 1) m_fatal = 1;
        m_age[b]++;
      end else m_age[b] = 0;
    end
    served = 0;
    if (acc) begin m_st = 2; m_start = 1; end
    else if (m_st == 2) begin
      if (dn) begin m_st = 3; m_start = 0; end
    end
    else if (m_req[1]) begin m_st = 0; served = 2'b10; end
    else if (m_req[0]) begin m_st = 1; served = 2'b01; end
    m_req = (m_req & ~served) | ((w && a == 0) ? d[1:0] : 2'b00);
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] e;
    cmp(tag, "eng_start", {31'b0, eng_start}, {31'b0, m_es});
    cmp(tag, "eng_cancel", {31'b0, eng_cancel}, {31'b0, m_ec});
    for (int a = 0; a < 4; a++) begin
      reg_raddr = a[1:0];
      #1;
      case (a)
        0: e = {30'b0, m_req};
        1: e = {30'b0, (m_st == 0), m_fatal};
        2: e = {31'b0, m_cancel};
        default: e = {31'b0, m_start};
      endcase
      cmp(tag, $sformatf("word%0d", a), reg_rdata, e);
    end
  endtask

  task automatic step(string tag, bit w, bit [1:0] a, logic [31:0] d, bit dn);
    reg_wr = w; reg_waddr = a; reg_wdata = d; eng_done = dn;
    @(posedge clk);
    model_edge(w, a, d, dn);
    @(negedge clk);
    reg_wr = 0; reg_waddr = 0; reg_wdata = 0; eng_done = 0;
    check_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 0;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_all(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_all("R1");                      // R1 reset state
    idle("R1", 2);

    step("R3", 1, 0, 32'h1, 0);           // R3 command-ready from idle
    idle("R3", 2);
    step("R5", 1, 3, 32'h2, 0);           // R5 wrong value ignored
    step("R5", 1, 3, 32'h1, 0);           // R5 launch
    idle("R5", 1);
    step("R6", 1, 3, 32'h0, 0);           // start word 0 ignored
    step("R7", 1, 2, 32'h1, 0);           // R7 cancel while executing
    step("R7", 1, 2, 32'h5, 0);           // R7 other value ignored
    step("R7", 1, 2, 32'h0, 0);           // R7 cleared
    step("R6", 0, 0, 0, 1);               // R6 done
    step("R6", 0, 0, 0, 1);               // R6 done in completion ignored
    step("R5", 1, 3, 32'h1, 0);           // R5 start in completion ignored
    step("R4", 1, 0, 32'h2, 0);           // R4 go-idle from completion
    idle("R4", 1);
    step("R6", 0, 0, 0, 1);               // R6 done in idle ignored
    step("R5", 1, 3, 32'h1, 0);           // R5 start in idle ignored
    step("R7", 1, 2, 32'h1, 0);           // R7 cancel outside exec: no strobe
    step("R7", 1, 2, 32'h0, 0);
    step("R4", 1, 0, 32'h3, 0);           // R4 both bits: go-idle first
    idle("R4", 3);

    step("R5", 1, 3, 32'h1, 0);           // launch again
    step("R2", 1, 0, 32'h1, 0);           // R2 command-ready while executing
    idle("R3", 3);                        // R3 stays pending
    step("R2", 1, 0, 32'h0, 0);           // R2 zero write keeps bit
    step("R6", 0, 0, 0, 1);               // R6 done, then R3 ready
    idle("R3", 2);
    step("R4", 1, 0, 32'h2, 0);           // R4 go-idle from ready
    idle("R4", 1);

    step("R3", 1, 0, 32'h1, 0);           // ready, launch, then hold request
    idle("R3", 1);
    step("R5", 1, 3, 32'h1, 0);
    step("R8", 1, 0, 32'h1, 0);           // R8 pending too long
    idle("R8", TMO + 2);
    step("R9", 0, 0, 0, 1);               // R9 fatal stays after service
    idle("R9", 4);
    step("R9", 1, 0, 32'h2, 0);
    idle("R9", 2);
    do_reset("R1");                       // R1 fatal cleared only by reset
    step("R8", 1, 0, 32'h2, 0);           // served quickly: no fatal
    idle("R8", TMO + 2);

    summary();
  end

endmodule